// File: doc/BRIEF.md
# Low-Power Sleep and Wake Controller

This block decides when a processor core parks itself in a low-power state and when it resumes. It holds a 32-bit sleep-configuration word with three live bits. It watches the wait-for-interrupt (WFI) and wait-for-event (WFE) requests, the send-event strobe, a vector of pending interrupts with its matching enable vector, and a strobe marking a return from an interrupt handler to thread code. From these it drives a sleep level, a deep-sleep level and a one-cycle wake strobe toward the clock and power logic.

A one-bit event latch remembers a wake-worthy event that arrives while the core is busy. The next WFE then consumes the latch and returns at once, without sleeping. A configuration bit widens the set of wake events so that an interrupt whose enable bit is clear also counts when it becomes pending. The clock gating, the power switches and the interrupt controller are outside this block.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0 and `sleep_o`, `deep_sleep_o`, `wake_o` and `event_latched_o` are all 0.
- R2: A write stores bit 4 (pending-wakes-all), bit 2 (deep select) and bit 1 (sleep on handler exit). Every other bit reads as 0 whatever was written, and `cfg_rd_data` shows the stored value one cycle after the write.
- R3: A WFI request while running raises `sleep_o` after the next clock edge. The block then wakes on any bit that is set in both `irq_pend` and `irq_en`: `sleep_o` falls and `wake_o` is high for exactly one cycle after that edge. A pending bit with a clear enable does not wake a WFI sleep.
- R4: A WFE request while running, with the latch clear and no event in the same cycle, raises `sleep_o` after the next edge. An event then clears `sleep_o` and pulses `wake_o` one cycle later, and the latch stays clear.
- R5: An event while running sets `event_latched_o` one cycle later. A later WFE clears the latch and pulses `wake_o` one cycle later, and `sleep_o` stays low.
- R6: An event is the send-event strobe, or a 0-to-1 change of any `irq_pend` bit. With bit 4 clear, such a change counts only if its `irq_en` bit is set. With bit 4 set, it counts regardless of `irq_en`.
- R7: `deep_sleep_o` equals `sleep_o` AND configuration bit 2, so it is never high while `sleep_o` is low.
- R8: With bit 1 set, a `handler_exit` strobe while running enters a sleep that wakes like a WFI sleep. With bit 1 clear, the strobe has no effect.
- R9: When requests coincide while running, WFE wins over WFI, and WFI wins over a handler exit. All three requests are ignored while asleep.
- R10: An event during a WFI sleep sets the latch without waking the core. A WFI sleep never clears the latch. This includes the interrupt that wakes it, whose rising edge is also an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration read data, reserved bits 0 |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfe_req | input | 1 | Wait-for-event request |
| sev_strobe | input | 1 | Send-event strobe |
| irq_pend | input | NUM_IRQ | Pending interrupt vector |
| irq_en | input | NUM_IRQ | Interrupt enable vector |
| handler_exit | input | 1 | Return from handler to thread strobe |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_sleep_o | output | 1 | Low-power state is deep sleep |
| wake_o | output | 1 | One-cycle wake strobe |
| event_latched_o | output | 1 | Event latch state |

## Verification
Every result is registered once. A request, event or pending edge applied before clock edge k shows on `sleep_o`, `wake_o` and `event_latched_o` just after edge k. `deep_sleep_o` follows in the same cycle, because it is a plain AND of `sleep_o` and the stored bit. A configuration write shows on `cfg_rd_data` just after its edge. The bench drives stimulus after the falling edge, steps exactly one rising edge, and samples at the next falling edge. It checks one-cycle pulses such as `wake_o` both at their due cycle and one cycle later, when they must have dropped.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int CFG_W         = 32;
    localparam int SEVP_BIT      = 4;
    localparam int DEEP_BIT      = 2;
    localparam int EXIT_BIT      = 1;

    typedef struct packed {
        logic any_pend_wakes;
        logic deep_sel;
        logic sleep_on_exit;
    } slp_cfg_t;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_WFI = 2'd1,
        ST_WFE = 2'd2
    } pwr_state_t;

    function automatic slp_cfg_t cfg_unpack(input logic [CFG_W-1:0] d);
        slp_cfg_t c;
        c.any_pend_wakes = d[SEVP_BIT];
        c.deep_sel       = d[DEEP_BIT];
        c.sleep_on_exit  = d[EXIT_BIT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input slp_cfg_t c);
        logic [CFG_W-1:0] d;
        d           = '0;
        d[SEVP_BIT] = c.any_pend_wakes;
        d[DEEP_BIT] = c.deep_sel;
        d[EXIT_BIT] = c.sleep_on_exit;
        return d;
    endfunction

endpackage

// File: rtl/slp_cfg_reg.sv
module slp_cfg_reg
    import slp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output slp_cfg_t         cfg,
    output logic [CFG_W-1:0] rd_data
);

    slp_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_unpack(wr_data);
        end
    end

    assign cfg     = cfg_q;
    assign rd_data = cfg_pack(cfg_q);

endmodule

// File: rtl/slp_evt_det.sv
module slp_evt_det #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] en,
    input  logic               any_pend_wakes,
    input  logic               sev,
    output logic               evt,
    output logic               irq_wake
);

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] rise_qual;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend;
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_edge
        assign rise[i]      = pend[i] & ~pend_q[i];
        assign rise_qual[i] = rise[i] & (en[i] | any_pend_wakes);
    end

    assign evt      = sev | (|rise_qual);
    assign irq_wake = |(pend & en);

endmodule

// File: rtl/slp_pwr_fsm.sv
module slp_pwr_fsm
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic handler_exit,
    input  logic sleep_on_exit,
    input  logic deep_sel,
    input  logic evt,
    input  logic irq_wake,
    output logic sleep,
    output logic deep_sleep,
    output logic wake,
    output logic latch
);

    pwr_state_t st_q, st_d;
    logic       latch_q, latch_d;
    logic       wake_q, wake_d;

    always_comb begin
        st_d    = st_q;
        latch_d = latch_q;
        wake_d  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (wfe_req) begin
                    if (latch_q || evt) begin
                        latch_d = 1'b0;
                        wake_d  = 1'b1;
                    end else begin
                        st_d = ST_WFE;
                    end
                end else begin
                    if (evt) latch_d = 1'b1;
                    if (wfi_req || (handler_exit && sleep_on_exit)) begin
                        st_d = ST_WFI;
                    end
                end
            end
            ST_WFI: begin
                if (evt) latch_d = 1'b1;
                if (irq_wake) begin
                    st_d   = ST_RUN;
                    wake_d = 1'b1;
                end
            end
            ST_WFE: begin
                if (evt) begin
                    st_d   = ST_RUN;
                    wake_d = 1'b1;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RUN;
            latch_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            latch_q <= latch_d;
            wake_q  <= wake_d;
        end
    end

    assign sleep      = (st_q != ST_RUN);
    assign deep_sleep = sleep & deep_sel;
    assign wake       = wake_q;
    assign latch      = latch_q;

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr_en,
    input  logic [CFG_W-1:0]   cfg_wr_data,
    output logic [CFG_W-1:0]   cfg_rd_data,
    input  logic               wfi_req,
    input  logic               wfe_req,
    input  logic               sev_strobe,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               handler_exit,
    output logic               sleep_o,
    output logic               deep_sleep_o,
    output logic               wake_o,
    output logic               event_latched_o
);

    slp_cfg_t cfg;
    logic     evt;
    logic     irq_wake;

    slp_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .rd_data (cfg_rd_data)
    );

    slp_evt_det #(.NUM_IRQ(NUM_IRQ)) u_evt (
        .clk            (clk),
        .rst            (rst),
        .pend           (irq_pend),
        .en             (irq_en),
        .any_pend_wakes (cfg.any_pend_wakes),
        .sev            (sev_strobe),
        .evt            (evt),
        .irq_wake       (irq_wake)
    );

    slp_pwr_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .wfi_req       (wfi_req),
        .wfe_req       (wfe_req),
        .handler_exit  (handler_exit),
        .sleep_on_exit (cfg.sleep_on_exit),
        .deep_sel      (cfg.deep_sel),
        .evt           (evt),
        .irq_wake      (irq_wake),
        .sleep         (sleep_o),
        .deep_sleep    (deep_sleep_o),
        .wake          (wake_o),
        .latch         (event_latched_o)
    );

endmodule

// File: rtl/slp_wake_chk.sv
module slp_wake_chk
    import slp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg_rd_data,
    input logic             wfe_req,
    input logic             sev_strobe,
    input logic             sleep_o,
    input logic             deep_sleep_o,
    input logic             wake_o,
    input logic             event_latched_o
);

    localparam logic [CFG_W-1:0] LIVE_MASK =
        (CFG_W'(1) << SEVP_BIT) | (CFG_W'(1) << DEEP_BIT) | (CFG_W'(1) << EXIT_BIT);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data & ~LIVE_MASK) == '0);                               // R2

    AST_DEEP_WITHIN_SLEEP: assert property (@(posedge clk) disable iff (rst)
        deep_sleep_o |-> sleep_o);                                       // R7

    AST_WAKE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> !sleep_o);                                            // R3

    AST_WFE_CONSUMES_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!sleep_o && wfe_req && event_latched_o) |=> (wake_o && !sleep_o && !event_latched_o)); // R5

    AST_SEV_SETS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!sleep_o && sev_strobe && !wfe_req) |=> event_latched_o);       // R5

    AST_WFE_WAKE_ON_SEV: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && !event_latched_o && sev_strobe && $past(wfe_req) && !wake_o)
        |=> (!sleep_o || event_latched_o));                              // R4

endmodule

bind slp_wake_ctrl slp_wake_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_rd_data     (cfg_rd_data),
    .wfe_req         (wfe_req),
    .sev_strobe      (sev_strobe),
    .sleep_o         (sleep_o),
    .deep_sleep_o    (deep_sleep_o),
    .wake_o          (wake_o),
    .event_latched_o (event_latched_o)
);

// File: tb/sim_slp_wake_ctrl.sv
module sim_slp_wake_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_wr_en;
    logic [31:0]     cfg_wr_data;
    logic [31:0]     cfg_rd_data;
    logic            wfi_req, wfe_req, sev_strobe, handler_exit;
    logic [NIRQ-1:0] irq_pend, irq_en;
    logic            sleep_o, deep_sleep_o, wake_o, event_latched_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_wake_ctrl #(.NUM_IRQ(NIRQ)) u0 (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .wfi_req(wfi_req), .wfe_req(wfe_req), .sev_strobe(sev_strobe),
        .irq_pend(irq_pend), .irq_en(irq_en), .handler_exit(handler_exit),
        .sleep_o(sleep_o), .deep_sleep_o(deep_sleep_o), .wake_o(wake_o),
        .event_latched_o(event_latched_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic outs(input string tag, input logic s, input logic d, input logic w, input logic l);
        check({tag, " sleep"}, 32'(sleep_o), 32'(s));
        check({tag, " deep"},  32'(deep_sleep_o), 32'(d));
        check({tag, " wake"},  32'(wake_o), 32'(w));
        check({tag, " latch"}, 32'(event_latched_o), 32'(l));
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v; step(); cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_wfi();   wfi_req = 1'b1; step(); wfi_req = 1'b0; endtask
    task automatic pulse_wfe();   wfe_req = 1'b1; step(); wfe_req = 1'b0; endtask
    task automatic pulse_sev();   sev_strobe = 1'b1; step(); sev_strobe = 1'b0; endtask

    // wake from WFI with enabled irq 0; its rising edge also latches (R10)
    task automatic wake_by_irq0(input string tag, input logic deep);
        irq_en[0] = 1'b1; irq_pend[0] = 1'b1; step();
        outs({tag, " wake"}, 1'b0, 1'b0, 1'b1, 1'b1);
        irq_pend[0] = 1'b0; step();
        outs({tag, " after"}, 1'b0, 1'b0, 1'b0, 1'b1);
        if (deep) check({tag, " deep unused"}, 32'(deep_sleep_o), 32'd0);
        pulse_wfe();   // drain latch: R5
        outs({tag, " drain"}, 1'b0, 1'b0, 1'b1, 1'b0);
        step();
    endtask

    task automatic t_reset();
        outs("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 cfg", cfg_rd_data, 32'h0);
    endtask

    task automatic t_cfg();
        wr_cfg(32'hFFFF_FFFF);
        check("R2 all ones", cfg_rd_data, 32'h16);
        wr_cfg(32'hFFFF_FFE9);
        check("R2 reserved only", cfg_rd_data, 32'h0);
        wr_cfg(32'h0000_0004);
        check("R2 bit2", cfg_rd_data, 32'h4);
        wr_cfg(32'h0);
    endtask

    task automatic t_wfi();
        pulse_wfi();
        outs("R3 wfi asleep", 1'b1, 1'b0, 1'b0, 1'b0);
        irq_en[3] = 1'b0; irq_pend[3] = 1'b1; step(); step();
        outs("R3 disabled pend holds sleep", 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 disabled rise not event", 32'(event_latched_o), 32'd0);
        irq_pend[3] = 1'b0; step();
        wake_by_irq0("R3", 1'b0);
        irq_en[0] = 1'b0;
    endtask

    task automatic t_wfe_sleep();
        pulse_wfe();
        outs("R4 wfe asleep", 1'b1, 1'b0, 1'b0, 1'b0);
        step();
        outs("R4 stays", 1'b1, 1'b0, 1'b0, 1'b0);
        pulse_sev();
        outs("R4 sev wakes", 1'b0, 1'b0, 1'b1, 1'b0);
        step();
        check("R4 wake one cycle", 32'(wake_o), 32'd0);
    endtask

    task automatic t_latch();
        pulse_sev();
        outs("R5 latched", 1'b0, 1'b0, 1'b0, 1'b1);
        step();
        check("R5 held", 32'(event_latched_o), 32'd1);
        pulse_wfe();
        outs("R5 consumed", 1'b0, 1'b0, 1'b1, 1'b0);
        step();
        outs("R5 after", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_any_pend();
        wr_cfg(32'h10);
        irq_en[5] = 1'b0; irq_pend[5] = 1'b1; step();
        check("R6 any-pend latches", 32'(event_latched_o), 32'd1);
        irq_pend[5] = 1'b0;
        pulse_wfe();
        check("R6 drained", 32'(event_latched_o), 32'd0);
        pulse_wfe();
        check("R6 wfe sleeps", 32'(sleep_o), 32'd1);
        irq_pend[6] = 1'b1; step();
        outs("R6 disabled irq wakes wfe", 1'b0, 1'b0, 1'b1, 1'b0);
        irq_pend[6] = 1'b0;
        wr_cfg(32'h0);
        irq_pend[7] = 1'b1; step();
        check("R6 masked again", 32'(event_latched_o), 32'd0);
        irq_pend[7] = 1'b0; step();
    endtask

    task automatic t_deep();
        wr_cfg(32'h4);
        pulse_wfi();
        outs("R7 deep", 1'b1, 1'b1, 1'b0, 1'b0);
        wake_by_irq0("R7", 1'b1);
        irq_en[0] = 1'b0;
        wr_cfg(32'h0);
        pulse_wfi();
        outs("R7 plain", 1'b1, 1'b0, 1'b0, 1'b0);
        wake_by_irq0("R7b", 1'b0);
        irq_en[0] = 1'b0;
    endtask

    task automatic t_exit();
        handler_exit = 1'b1; step(); handler_exit = 1'b0;
        outs("R8 exit ignored", 1'b0, 1'b0, 1'b0, 1'b0);
        wr_cfg(32'h2);
        handler_exit = 1'b1; step(); handler_exit = 1'b0;
        outs("R8 exit sleeps", 1'b1, 1'b0, 1'b0, 1'b0);
        pulse_sev();
        outs("R8 wfi-like: sev latches only", 1'b1, 1'b0, 1'b0, 1'b1);
        irq_en[0] = 1'b1; irq_pend[0] = 1'b1; step();
        outs("R8 irq wakes", 1'b0, 1'b0, 1'b1, 1'b1);
        irq_pend[0] = 1'b0; irq_en[0] = 1'b0;
        pulse_wfe();
        wr_cfg(32'h0);
    endtask

    task automatic t_prio();
        wfe_req = 1'b1; wfi_req = 1'b1; step(); wfe_req = 1'b0; wfi_req = 1'b0;
        check("R9 asleep", 32'(sleep_o), 32'd1);
        pulse_wfi();
        check("R9 wfi ignored asleep", 32'(sleep_o), 32'd1);
        pulse_sev();
        outs("R9 wfe won: sev wakes", 1'b0, 1'b0, 1'b1, 1'b0);
        wr_cfg(32'h2);
        wfi_req = 1'b1; handler_exit = 1'b1; step();
        wfi_req = 1'b0; handler_exit = 1'b0;
        check("R9 wfi over exit", 32'(sleep_o), 32'd1);
        wfe_req = 1'b1; step(); wfe_req = 1'b0;
        outs("R9 wfe ignored asleep", 1'b1, 1'b0, 1'b0, 1'b0);
        wake_by_irq0("R9", 1'b0);
        irq_en[0] = 1'b0;
        wr_cfg(32'h0);
    endtask

    task automatic t_wfi_evt();
        pulse_wfi();
        pulse_sev();
        outs("R10 sev in wfi", 1'b1, 1'b0, 1'b0, 1'b1);
        step();
        outs("R10 still asleep", 1'b1, 1'b0, 1'b0, 1'b1);
        wake_by_irq0("R10", 1'b0);
        irq_en[0] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        wfi_req = 1'b0; wfe_req = 1'b0; sev_strobe = 1'b0; handler_exit = 1'b0;
        irq_pend = '0; irq_en = '0;
        @(negedge clk); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_cfg();
        t_wfi();
        t_wfe_sleep();
        t_latch();
        t_any_pend();
        t_deep();
        t_exit();
        t_prio();
        t_wfi_evt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule